// File: doc/BRIEF.md
# Core Sleep State Sequencer

This block is the per-core power-state controller. It receives a target sleep depth that has already been resolved for the core. It then steps the core into that depth and back out through a chain of request/acknowledge handshakes: cache flush, clock gate, state save to local memory, voltage off, voltage on and state restore. There are four depths:

- run
- light halt, where clocks stay on and snoops are still answered
- clock-stopped, where the caches are first written back to the shared cache
- power-gated, where the caches are written back, the architectural state is saved, and only then is the voltage removed

A wake input ends a sleep. A snoop input is answered or ignored, depending on how deep the core is. A 4-bit status output shows the current step of the sequence, and a busy output marks the whole excursion away from run. A wake that arrives during an entry sequence is held until the handshake in flight completes. The exit then undoes only the steps that were actually carried out.

Top module: `core_sleep_seq`

## Requirements
- R1: After reset, status is 0, busy is 0 and every handshake request is low. A request with depth code 0 (run) or with codes 5 to 7 changes none of these outputs.
- R2: A request with depth code 1 (light halt) moves status to 1 with busy high and raises no handshake request. A later wake pulse returns status to 0.
- R3: In status 0 or 1, a snoop pulse gives a one-cycle snoop_ack in the following cycle. A snoop in light halt leaves status at 1.
- R4: Depth code 2 (clock-stopped) first raises flush_req. After flush_ack it raises cg_req and holds it until cg_ack goes high, and the core then rests at status 4. On wake, cg_req drops and status returns to 0 once cg_ack is low.
- R5: In status 4 or 7, a snoop gives no snoop_ack and does not move status.
- R6: Depth code 3 (power-gated) raises flush_req, then save_req, then voff_req, each only after the previous acknowledge. It then rests at status 7 without touching cg_req.
- R7: A wake from status 7 raises von_req first and rest_req only after von_ack. Status then returns to 0 after rest_ack.
- R8: Depth code 4 (deepest) produces exactly the same handshake order and status codes as depth code 3.
- R9: Each step holds its request until its acknowledge arrives, and it advances by one step per acknowledge. The status codes are: 0 run, 1 halt, 2 flush, 3 clock gate, 4 clock-stopped, 5 save, 6 voltage off, 7 power-gated, 8 voltage on, 9 restore, 10 clock ungate.
- R10: A wake during an entry step leaves status at that step until its acknowledge arrives. The exit then depends on where the wake arrived:
  - during flush or save: straight to 0, with no other handshake
  - during clock gate: ungate, then 0
  - during voltage off: voltage on, restore, then 0
- R11: busy is high exactly when status is not 0. A depth request made while busy is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Depth request strobe |
| req_depth | input | 3 | Requested depth code (0 run, 1 halt, 2 clock-stopped, 3 power-gated, 4 deepest) |
| wake | input | 1 | Wake event |
| snoop | input | 1 | Incoming snoop |
| snoop_ack | output | 1 | Snoop serviced |
| flush_req | output | 1 | Cache write-back request |
| flush_ack | input | 1 | Cache write-back done |
| cg_req | output | 1 | Clock-stop level request |
| cg_ack | input | 1 | Clock-stop level acknowledge |
| save_req | output | 1 | State save request |
| save_ack | input | 1 | State save done |
| voff_req | output | 1 | Voltage removal request |
| voff_ack | input | 1 | Voltage removal done |
| von_req | output | 1 | Voltage restore request |
| von_ack | input | 1 | Voltage restore done |
| rest_req | output | 1 | State restore request |
| rest_ack | input | 1 | State restore done |
| busy | output | 1 | Core away from run |
| status | output | 4 | Current sequence step code |

## Verification
A wrong internal step is visible on status at once, because status is the state register itself. It also appears within one cycle as the wrong handshake request, or as a request out of order. The bench therefore records the order in which requests rise and compares it with the order the requirement gives.

A lost or wrongly kept pending wake appears as an exit that undoes too few or too many steps. A snoop policy fault appears as a snoop_ack one cycle after the snoop.

// File: rtl/cs_pkg.sv
package cs_pkg;
  typedef enum logic [3:0] {
    ST_RUN     = 4'd0,
    ST_HALT    = 4'd1,
    ST_FLUSH   = 4'd2,
    ST_CGATE   = 4'd3,
    ST_CSTOP   = 4'd4,
    ST_SAVE    = 4'd5,
    ST_VOFF    = 4'd6,
    ST_PGATED  = 4'd7,
    ST_VON     = 4'd8,
    ST_RESTORE = 4'd9,
    ST_CUNGATE = 4'd10
  } seq_st_e;

  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_HALT = 2'd1,
    TGT_MID  = 2'd2,
    TGT_DEEP = 2'd3
  } tgt_e;
endpackage

// File: rtl/cs_rst_sync.sv
module cs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/cs_req_decode.sv
module cs_req_decode
  import cs_pkg::*;
#(
  parameter int DEPTH_W = 3
) (
  input  logic               req_valid,
  input  logic [DEPTH_W-1:0] req_depth,
  output tgt_e               tgt
);
  localparam logic [DEPTH_W-1:0] CODE_HALT    = DEPTH_W'(1);
  localparam logic [DEPTH_W-1:0] CODE_MID     = DEPTH_W'(2);
  localparam logic [DEPTH_W-1:0] CODE_DEEP    = DEPTH_W'(3);
  localparam logic [DEPTH_W-1:0] CODE_DEEPEST = DEPTH_W'(4);

  always_comb begin
    tgt = TGT_NONE;
    if (req_valid) begin
      if (req_depth == CODE_HALT)                                 tgt = TGT_HALT;
      else if (req_depth == CODE_MID)                             tgt = TGT_MID;
      else if (req_depth == CODE_DEEP || req_depth == CODE_DEEPEST) tgt = TGT_DEEP;
    end
  end
endmodule

// File: rtl/cs_seq_fsm.sv
module cs_seq_fsm
  import cs_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  tgt_e    tgt,
  input  logic    wake,
  input  logic    flush_ack,
  input  logic    cg_ack,
  input  logic    save_ack,
  input  logic    voff_ack,
  input  logic    von_ack,
  input  logic    rest_ack,
  output seq_st_e st,
  output logic    clk_on
);
  seq_st_e st_q, st_d;
  logic    deep_q, deep_d, deep_en;
  logic    pend_q, pend_d;
  logic    wake_any, entry_step, st_en;

  assign wake_any   = wake | pend_q;
  assign entry_step = (st_q == ST_FLUSH) || (st_q == ST_CGATE) ||
                      (st_q == ST_SAVE)  || (st_q == ST_VOFF);

  always_comb begin
    st_d    = st_q;
    deep_d  = deep_q;
    deep_en = 1'b0;
    unique case (st_q)
      ST_RUN: begin
        if (tgt == TGT_HALT) st_d = ST_HALT;
        else if (tgt == TGT_MID || tgt == TGT_DEEP) begin
          st_d    = ST_FLUSH;
          deep_d  = (tgt == TGT_DEEP);
          deep_en = 1'b1;
        end
      end
      ST_HALT:    if (wake) st_d = ST_RUN;
      ST_FLUSH:   if (flush_ack) st_d = wake_any ? ST_RUN : (deep_q ? ST_SAVE : ST_CGATE);
      ST_CGATE:   if (cg_ack)    st_d = wake_any ? ST_CUNGATE : ST_CSTOP;
      ST_CSTOP:   if (wake)      st_d = ST_CUNGATE;
      ST_CUNGATE: if (!cg_ack)   st_d = ST_RUN;
      ST_SAVE:    if (save_ack)  st_d = wake_any ? ST_RUN : ST_VOFF;
      ST_VOFF:    if (voff_ack)  st_d = wake_any ? ST_VON : ST_PGATED;
      ST_PGATED:  if (wake)      st_d = ST_VON;
      ST_VON:     if (von_ack)   st_d = ST_RESTORE;
      ST_RESTORE: if (rest_ack)  st_d = ST_RUN;
      default:    st_d = ST_RUN;
    endcase
  end

  assign st_en  = (st_d != st_q);
  assign pend_d = entry_step && !st_en && wake_any;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_RUN;
    else if (st_en) st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) deep_q <= 1'b0;
    else if (deep_en) deep_q <= deep_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  assign st     = st_q;
  assign clk_on = (st_q == ST_RUN) || (st_q == ST_HALT) || (st_q == ST_FLUSH);

  // R9
  flush_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_FLUSH && !flush_ack) |=> (st_q == ST_FLUSH));

  // R10
  held_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_VOFF && voff_ack && pend_q) |=> (st_q == ST_VON));

  // R11
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_HALT && !wake) |=> (st_q == ST_HALT));
endmodule

// File: rtl/cs_snoop_filter.sv
module cs_snoop_filter
  import cs_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    snoop,
  input  logic    clk_on,
  input  seq_st_e st,
  output logic    snoop_ack
);
  logic ack_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ack_q <= 1'b0;
    else        ack_q <= snoop && clk_on;
  end

  assign snoop_ack = ack_q;

  // R5
  snoop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snoop && (st == ST_CSTOP || st == ST_PGATED)) |=> !snoop_ack);

  // R3
  snoop_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snoop && st == ST_HALT) |=> snoop_ack);
endmodule

// File: rtl/core_sleep_seq.sv
module core_sleep_seq
  import cs_pkg::*;
#(
  parameter int DEPTH_W     = 3,
  parameter int SYNC_STAGES = 2,
  parameter int STATUS_W    = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [DEPTH_W-1:0] req_depth,
  input  logic               wake,
  input  logic               snoop,
  output logic               snoop_ack,
  output logic               flush_req,
  input  logic               flush_ack,
  output logic               cg_req,
  input  logic               cg_ack,
  output logic               save_req,
  input  logic               save_ack,
  output logic               voff_req,
  input  logic               voff_ack,
  output logic               von_req,
  input  logic               von_ack,
  output logic               rest_req,
  input  logic               rest_ack,
  output logic               busy,
  output logic [STATUS_W-1:0] status
);
  logic    rst_n_i, clk_on;
  tgt_e    tgt;
  seq_st_e st;

  cs_rst_sync #(.STAGES(SYNC_STAGES)) i_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_i));

  cs_req_decode #(.DEPTH_W(DEPTH_W)) i_dec (
    .req_valid(req_valid), .req_depth(req_depth), .tgt(tgt));

  cs_seq_fsm i_fsm (
    .clk(clk), .rst_n(rst_n_i), .tgt(tgt), .wake(wake),
    .flush_ack(flush_ack), .cg_ack(cg_ack), .save_ack(save_ack),
    .voff_ack(voff_ack), .von_ack(von_ack), .rest_ack(rest_ack),
    .st(st), .clk_on(clk_on));

  cs_snoop_filter i_snp (
    .clk(clk), .rst_n(rst_n_i), .snoop(snoop), .clk_on(clk_on),
    .st(st), .snoop_ack(snoop_ack));

  assign flush_req = (st == ST_FLUSH);
  assign cg_req    = (st == ST_CGATE) || (st == ST_CSTOP);
  assign save_req  = (st == ST_SAVE);
  assign voff_req  = (st == ST_VOFF);
  assign von_req   = (st == ST_VON);
  assign rest_req  = (st == ST_RESTORE);
  assign busy      = (st != ST_RUN);
  assign status    = STATUS_W'(st);

  // R6
  voff_after_save_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    $rose(voff_req) |-> $past(save_req && save_ack));

  // R7
  restore_after_von_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    $rose(rest_req) |-> $past(von_req && von_ack));

  // R4
  cg_release_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    (status == 4'd10 && cg_ack) |=> (status == 4'd10));
endmodule

// File: tb/test_core_sleep_seq.sv
module tb_hs_stub (
  input  logic clk,
  input  logic req,
  input  logic hold,
  input  int   dly,
  output logic ack
);
  int cnt;
  initial begin ack = 1'b0; cnt = 0; end
  always @(negedge clk) begin
    if (req && !ack && !hold) begin
      if (cnt + 1 >= dly) begin ack = 1'b1; cnt = 0; end
      else cnt = cnt + 1;
    end else begin
      ack = 1'b0;
      if (!req) cnt = 0;
    end
  end
endmodule

module test_core_sleep_seq;
  logic clk = 1'b0;
  logic rst_n, req_valid, wake, snoop, hold;
  logic [2:0] req_depth;
  logic snoop_ack, flush_req, flush_ack, cg_req, cg_ack, save_req, save_ack;
  logic voff_req, voff_ack, von_req, von_ack, rest_req, rest_ack, busy;
  logic [3:0] status;
  int d_flush = 2, d_cg = 2, d_save = 2, d_voff = 2, d_von = 2, d_rest = 2;
  int checks = 0, fails = 0, cgcnt = 0;
  string log_s = "";
  logic [6:0] prev = '0;

  always #10 clk = ~clk;

  core_sleep_seq i_core_sleep_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_depth(req_depth),
    .wake(wake), .snoop(snoop), .snoop_ack(snoop_ack),
    .flush_req(flush_req), .flush_ack(flush_ack), .cg_req(cg_req), .cg_ack(cg_ack),
    .save_req(save_req), .save_ack(save_ack), .voff_req(voff_req), .voff_ack(voff_ack),
    .von_req(von_req), .von_ack(von_ack), .rest_req(rest_req), .rest_ack(rest_ack),
    .busy(busy), .status(status));

  tb_hs_stub s_fl (.clk(clk), .req(flush_req), .hold(hold), .dly(d_flush), .ack(flush_ack));
  tb_hs_stub s_sv (.clk(clk), .req(save_req),  .hold(hold), .dly(d_save),  .ack(save_ack));
  tb_hs_stub s_vf (.clk(clk), .req(voff_req),  .hold(hold), .dly(d_voff),  .ack(voff_ack));
  tb_hs_stub s_vn (.clk(clk), .req(von_req),   .hold(hold), .dly(d_von),   .ack(von_ack));
  tb_hs_stub s_rs (.clk(clk), .req(rest_req),  .hold(hold), .dly(d_rest),  .ack(rest_ack));

  initial cg_ack = 1'b0;
  always @(negedge clk) begin
    if (cg_ack != cg_req && !hold) begin
      cgcnt = cgcnt + 1;
      if (cgcnt >= d_cg) begin cg_ack = cg_req; cgcnt = 0; end
    end else cgcnt = 0;
  end

  // order monitor: F flush, G gate, U ungate, S save, O off, N on, R restore
  always @(negedge clk) begin
    if (flush_req && !prev[0]) log_s = {log_s, "F"};
    if (cg_req && !prev[1])    log_s = {log_s, "G"};
    if (!cg_req && prev[1])    log_s = {log_s, "U"};
    if (save_req && !prev[2])  log_s = {log_s, "S"};
    if (voff_req && !prev[3])  log_s = {log_s, "O"};
    if (von_req && !prev[4])   log_s = {log_s, "N"};
    if (rest_req && !prev[5])  log_s = {log_s, "R"};
    prev = {1'b0, rest_req, von_req, voff_req, save_req, cg_req, flush_req};
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run hung, actual running expected done");
    summary();
    $finish;
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chk_s(string tag, string act, string exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual \"%s\" expected \"%s\"", tag, act, exp);
    end
  endtask

  task automatic wait_st(int code);
    for (int i = 0; i < 200 && status != 4'(code); i++) @(negedge clk);
  endtask

  task automatic request(int d);
    @(negedge clk);
    log_s = "";
    req_valid = 1'b1; req_depth = 3'(d);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic pulse_wake();
    @(negedge clk); wake = 1'b1;
    @(negedge clk); wake = 1'b0;
  endtask

  task automatic pulse_snoop(output logic seen);
    @(negedge clk); snoop = 1'b1;
    @(negedge clk); snoop = 1'b0; seen = snoop_ack;
  endtask

  task automatic t_reset();
    chk("R1 reset status", status, 0);
    chk("R1 reset busy", busy, 0);
    chk("R1 reset reqs", {flush_req, cg_req, save_req, voff_req, von_req, rest_req}, 0);
  endtask

  task automatic t_run_noop();
    logic s;
    request(0); cyc(4);
    chk("R1 depth0 status", status, 0);
    request(6); cyc(4);
    chk("R1 depth6 status", status, 0);
    chk_s("R1 no handshake", log_s, "");
    pulse_snoop(s);
    chk("R3 snoop in run", s, 1);
  endtask

  task automatic t_halt();
    logic s;
    request(1); cyc(3);
    chk("R2 halt status", status, 1);
    chk("R11 halt busy", busy, 1);
    pulse_snoop(s);
    chk("R3 snoop ack in halt", s, 1);
    cyc(1);
    chk("R3 stays halt", status, 1);
    request(2); cyc(4);
    chk("R11 request ignored", status, 1);
    chk_s("R11 no flush", log_s, "");
    pulse_wake(); cyc(1);
    chk("R2 wake to run", status, 0);
    chk("R11 busy low", busy, 0);
  endtask

  task automatic t_mid();
    logic s;
    request(2); wait_st(4);
    chk("R4 mid rest status", status, 4);
    chk_s("R4 mid entry order", log_s, "FG");
    pulse_snoop(s);
    chk("R5 no snoop ack mid", s, 0);
    cyc(3);
    chk("R5 mid not woken", status, 4);
    pulse_wake(); wait_st(0); cyc(1);
    chk_s("R4 mid full order", log_s, "FGU");
    chk("R4 cg released", {cg_req, cg_ack}, 0);
  endtask

  task automatic t_deep(int d, string tag);
    logic s;
    request(d); wait_st(7);
    chk({tag, " deep rest status"}, status, 7);
    chk_s({tag, " deep entry order"}, log_s, "FSO");
    pulse_snoop(s);
    chk("R5 no snoop ack deep", s, 0);
    cyc(3);
    chk("R5 deep not woken", status, 7);
    pulse_wake(); wait_st(0); cyc(1);
    chk_s({tag, " deep full order"}, log_s, "FSONR");
  endtask

  task automatic t_hold();
    hold = 1'b1;
    request(3); wait_st(2); cyc(10);
    chk("R9 waits on ack status", status, 2);
    chk("R9 flush req held", flush_req, 1);
    hold = 1'b0;
    wait_st(5);
    chk("R9 one step per ack", status, 5);
    wait_st(7);
    pulse_wake(); wait_st(0); cyc(1);
  endtask

  task automatic t_wake_entry(int d, int at, string exp);
    d_flush = 6; d_cg = 6; d_save = 6; d_voff = 6;
    request(d); wait_st(at);
    pulse_wake();
    chk($sformatf("R10 held at step %0d", at), status, at);
    wait_st(0); cyc(2);
    chk($sformatf("R10 back to run from %0d", at), status, 0);
    chk_s($sformatf("R10 unwind from %0d", at), log_s, exp);
    d_flush = 2; d_cg = 2; d_save = 2; d_voff = 2;
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_depth = '0; wake = 1'b0; snoop = 1'b0; hold = 1'b0;
    cyc(3);
    rst_n = 1'b1;
    cyc(4);
    t_reset();
    t_run_noop();
    t_halt();
    t_mid();
    t_deep(3, "R6 R7");
    t_deep(4, "R8");
    t_hold();
    t_wake_entry(2, 2, "F");
    t_wake_entry(2, 3, "FGU");
    t_wake_entry(3, 5, "FS");
    t_wake_entry(3, 6, "FSONR");
    summary();
    $finish;
  end
endmodule